// File: doc/BRIEF.md
# Receive Frame Header Checker

This block watches the byte stream coming up from the radio baseband and decides, as early as the frame allows, whether the frame is worth keeping. A frame is one run of bytes marked by a start flag on its first byte and an end flag on its last. The first part is the physical-layer header: `PLCP_DATA_BYTES` bytes followed by a 16-bit check value. The MAC header follows it, then the frame body, then a 32-bit frame check sequence.

The block verifies the physical-header check value, the protocol version and the destination address. It stops processing the frame at the first check that fails. When the MAC header has passed every check, it reports the frame type to the transmit side. At the end of the frame it checks the 32-bit sequence. Every finished or abandoned frame gives a one-cycle accept or abort pulse and a result code in a status register. It also raises a host interrupt, which stays asserted until the host reads the status.

Layout of each frame, counted from the byte with the start flag:
- Positions 0 to `PLCP_DATA_BYTES+1` hold the physical header.
- The frame control byte sits at position `PLCP_DATA_BYTES+2`. Its bits [1:0] are the version and bits [3:2] are the type.
- Positions +1 to +3 after it are skipped.
- The next six bytes are destination address 1, with the first byte on the line first.

Top module: `rxh_checker`

## Requirements
- R1: The physical header is protected by CRC-16 with polynomial 0x1021 and preset 0xFFFF. Each byte is fed MSB first. The check value is sent high byte first and is not complemented, so running over all header bytes leaves 0. Any other result aborts the frame with status 1, decided on the last header byte.
- R2: If frame control bits [1:0] differ from `PROTO_VERSION` (default 0), the frame aborts with status 2, decided on the frame control byte.
- R3: Address 1 passes when bit 0 of its first byte (the group bit) is 1, or when all six bytes equal `station_addr`. `station_addr[7:0]` is compared with the first address byte and `station_addr[47:40]` with the last. Otherwise the frame aborts with status 3, decided on the last address byte.
- R4: When the last address byte completes a passing header, and that byte is not also the end of the frame, `hdr_ok` pulses for one cycle. At the same time `frame_kind` carries frame control bits [3:2]: 0 management, 1 control, 2 data.
- R5: The CRC-32 uses polynomial 0x04C11DB7 and preset all ones. It covers the bytes from frame control up to and including the frame check sequence. Bits are fed LSB first and the check sequence is the complemented value, low byte first. At the end flag, a register value of 0xC704DD7B gives `frame_accept` with status 0. Any other value gives `frame_abort` with status 4.
- R6: An end flag that arrives at or before the last address byte aborts the frame with status 4, unless a check on that same byte fails first. The priority is R1, then R2, then R3, then the end flag.
- R7: After an abort, no further byte of that frame causes `hdr_ok`, `frame_accept` or `frame_abort`.
- R8: Each verdict writes `rx_status` and sets `host_irq`. `rx_status` changes only on a verdict. `host_irq` stays set until a cycle with `status_rd` high and no new verdict. A verdict in the same cycle as a read leaves `host_irq` set.
- R9: A start flag always begins a new frame, even in the middle of another one. The unfinished frame gives no verdict.
- R10: After reset, `rx_status` is 0 and `host_irq`, `hdr_ok`, `frame_accept` and `frame_abort` are 0.
- R11: Every pulse and status update appears in the cycle after the clock edge that samples the deciding byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Own address, first line byte in bits [7:0] |
| status_rd | input | 1 | Host reads the status register, clears the interrupt |
| hdr_ok | output | 1 | One-cycle pulse: header checks passed |
| frame_kind | output | 2 | Frame type field, valid with `hdr_ok` |
| frame_accept | output | 1 | One-cycle pulse: frame complete and good |
| frame_abort | output | 1 | One-cycle pulse: frame dropped |
| rx_status | output | 3 | Last result: 0 ok, 1 header CRC, 2 version, 3 address, 4 frame check |
| host_irq | output | 1 | Result waiting for the host |

## Verification
Most internal faults show up at the ports in the cycle after the deciding byte. A wrong byte position counter moves the header-CRC, version or address verdict onto a different byte, so the abort pulse arrives at the wrong time, or the wrong check fires. A corrupted CRC state shows as a false abort, or a missing abort, on the last header byte or on the end flag. A wrong frame state shows either as pulses from the bytes after an abort, or as no verdict at all. Interrupt faults show up when an unread result is followed by another frame, or when a read coincides with a verdict.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_HDR_CRC = 3'd1,
        ST_VERSION = 3'd2,
        ST_ADDR    = 3'd3,
        ST_FCS     = 3'd4
    } rx_status_e;

    typedef enum logic [1:0] {
        KIND_MGMT = 2'd0,
        KIND_CTRL = 2'd1,
        KIND_DATA = 2'd2,
        KIND_RSVD = 2'd3
    } frame_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } rx_beat_t;

    typedef struct packed {
        logic       post;
        rx_status_e code;
    } verdict_t;

    localparam logic [15:0] HCRC_POLY    = 16'h1021;
    localparam logic [15:0] HCRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] HCRC_GOOD    = 16'h0000;
    localparam logic [31:0] FCS_POLY     = 32'h04C11DB7;
    localparam logic [31:0] FCS_PRESET   = 32'hFFFFFFFF;
    localparam logic [31:0] FCS_RESIDUE  = 32'hC704DD7B;

endpackage

// File: rtl/rxh_crc.sv
module rxh_crc #(
    parameter int              WIDTH     = 16,
    parameter logic [WIDTH-1:0] POLY     = '0,
    parameter logic [WIDTH-1:0] PRESET   = '1,
    parameter bit              LSB_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [7:0]       data,
    output logic [WIDTH-1:0] nxt
);

    logic [7:0]       feed;
    logic [WIDTH-1:0] crc_q;

    // feed[i] is the i-th bit shifted into the register
    if (LSB_FIRST) begin : g_lsb
        assign feed = data;
    end else begin : g_msb
        for (genvar i = 0; i < 8; i++) begin : g_rev
            assign feed[i] = data[7-i];
        end
    end

    always_comb begin
        logic [WIDTH-1:0] c;
        logic             fb;
        c = restart ? PRESET : crc_q;
        for (int i = 0; i < 8; i++) begin
            fb = c[WIDTH-1] ^ feed[i];
            c  = {c[WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        nxt = c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= PRESET;
        end else if (en) begin
            crc_q <= nxt;
        end
    end

endmodule

// File: rtl/rxh_addr_match.sv
module rxh_addr_match (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       first,
    input  logic [7:0] data,
    input  logic [7:0] expect_byte,
    output logic       pass
);

    logic grp_q;
    logic match_q;
    logic grp_now;
    logic match_now;

    assign grp_now   = first ? data[0] : grp_q;
    assign match_now = (first ? 1'b1 : match_q) & (data == expect_byte);
    assign pass      = grp_now | match_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q   <= 1'b0;
            match_q <= 1'b0;
        end else if (en) begin
            grp_q   <= grp_now;
            match_q <= match_now;
        end
    end

endmodule

// File: rtl/rxh_verdict.sv
module rxh_verdict
    import rxh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  verdict_t   vd,
    input  logic       status_rd,
    output rx_status_e status,
    output logic       irq,
    output logic       accept,
    output logic       abort
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ST_OK;
            irq    <= 1'b0;
            accept <= 1'b0;
            abort  <= 1'b0;
        end else begin
            accept <= vd.post & (vd.code == ST_OK);
            abort  <= vd.post & (vd.code != ST_OK);
            if (vd.post) begin
                status <= vd.code;
                irq    <= 1'b1;
            end else if (status_rd) begin
                irq    <= 1'b0;
            end
        end
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        vd.post |=> irq); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !status_rd) |=> irq); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !vd.post) |=> !irq); // R8
    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (rst)
        !vd.post |=> $stable(status)); // R8
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(accept && abort)); // R5
    AST_ABORT_CODE: assert property (@(posedge clk) disable iff (rst)
        abort |-> (status != ST_OK)); // R1

endmodule

// File: rtl/rxh_checker.sv
module rxh_checker
    import rxh_pkg::*;
#(
    parameter int         PLCP_DATA_BYTES = 4,
    parameter int         ADDR_BYTES      = 6,
    parameter logic [1:0] PROTO_VERSION   = 2'd0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    status_rd,
    output logic                    hdr_ok,
    output logic [1:0]              frame_kind,
    output logic                    frame_accept,
    output logic                    frame_abort,
    output logic [2:0]              rx_status,
    output logic                    host_irq
);

    localparam int PLCP_LEN   = PLCP_DATA_BYTES + 2;
    localparam int FC_AT      = PLCP_LEN;
    localparam int ADDR_FIRST = PLCP_LEN + 4;
    localparam int ADDR_LAST  = ADDR_FIRST + ADDR_BYTES - 1;
    localparam int POS_MAX    = ADDR_LAST + 1;
    localparam int POS_W      = $clog2(POS_MAX + 1);
    localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    localparam logic [POS_W-1:0] P_HDR_LAST   = POS_W'(PLCP_LEN - 1);
    localparam logic [POS_W-1:0] P_FC         = POS_W'(FC_AT);
    localparam logic [POS_W-1:0] P_ADDR_FIRST = POS_W'(ADDR_FIRST);
    localparam logic [POS_W-1:0] P_ADDR_LAST  = POS_W'(ADDR_LAST);
    localparam logic [POS_W-1:0] P_MAX        = POS_W'(POS_MAX);

    rx_beat_t         beat;
    seq_state_e       state_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic [1:0]       kind_q;
    logic             hdr_ok_q;

    logic             beat_start;
    logic             beat_live;
    logic [15:0]      hcrc_nxt;
    logic [31:0]      fcs_nxt;
    logic             in_addr;
    logic [IDX_W-1:0] addr_idx;
    logic             addr_pass;
    logic [7:0]       self_bytes [ADDR_BYTES];

    logic             f_hdr;
    logic             f_ver;
    logic             f_addr;
    logic             at_addr_last;
    logic             end_ev;
    verdict_t         vd;
    rx_status_e       status_e;

    assign beat = '{vld: rx_valid, sof: rx_sof, eof: rx_eof, data: rx_data};

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_self
        assign self_bytes[k] = station_addr[k*8 +: 8];
    end

    // ---------------- byte position tracking ----------------
    assign beat_start = beat.vld & beat.sof;
    assign beat_live  = beat_start | (beat.vld & (state_q == SEQ_RUN));
    assign cur_pos    = beat_start ? '0 : pos_q;

    assign in_addr  = beat_live && (cur_pos >= P_ADDR_FIRST) && (cur_pos <= P_ADDR_LAST);
    assign addr_idx = IDX_W'(cur_pos - P_ADDR_FIRST);

    // ---------------- checkers ----------------
    rxh_crc #(
        .WIDTH    (16),
        .POLY     (HCRC_POLY),
        .PRESET   (HCRC_PRESET),
        .LSB_FIRST(1'b0)
    ) i_hcrc (
        .clk    (clk),
        .rst    (rst),
        .en     (beat_live && (cur_pos <= P_HDR_LAST)),
        .restart(beat_start),
        .data   (beat.data),
        .nxt    (hcrc_nxt)
    );

    rxh_crc #(
        .WIDTH    (32),
        .POLY     (FCS_POLY),
        .PRESET   (FCS_PRESET),
        .LSB_FIRST(1'b1)
    ) i_fcs (
        .clk    (clk),
        .rst    (rst),
        .en     (beat_live && (cur_pos >= P_FC)),
        .restart(cur_pos == P_FC),
        .data   (beat.data),
        .nxt    (fcs_nxt)
    );

    rxh_addr_match i_addr (
        .clk        (clk),
        .rst        (rst),
        .en         (in_addr),
        .first      (cur_pos == P_ADDR_FIRST),
        .data       (beat.data),
        .expect_byte(self_bytes[addr_idx]),
        .pass       (addr_pass)
    );

    assign f_hdr        = beat_live && (cur_pos == P_HDR_LAST) && (hcrc_nxt != HCRC_GOOD);
    assign f_ver        = beat_live && (cur_pos == P_FC) && (beat.data[1:0] != PROTO_VERSION);
    assign at_addr_last = beat_live && (cur_pos == P_ADDR_LAST);
    assign f_addr       = at_addr_last && !addr_pass;
    assign end_ev       = beat_live && beat.eof;

    always_comb begin
        vd.post = f_hdr | f_ver | f_addr | end_ev;
        vd.code = ST_OK;
        if (f_hdr) begin
            vd.code = ST_HDR_CRC;
        end else if (f_ver) begin
            vd.code = ST_VERSION;
        end else if (f_addr) begin
            vd.code = ST_ADDR;
        end else if (end_ev) begin
            if (cur_pos <= P_ADDR_LAST) begin
                vd.code = ST_FCS;
            end else if (fcs_nxt != FCS_RESIDUE) begin
                vd.code = ST_FCS;
            end
        end
    end

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            pos_q    <= '0;
            kind_q   <= KIND_MGMT;
            hdr_ok_q <= 1'b0;
        end else begin
            hdr_ok_q <= at_addr_last && addr_pass && !beat.eof;
            if (vd.post) begin
                state_q <= SEQ_IDLE;
            end else if (beat_start) begin
                state_q <= SEQ_RUN;
            end
            if (beat_live) begin
                pos_q <= (cur_pos == P_MAX) ? P_MAX : cur_pos + 1'b1;
            end
            if (beat_live && (cur_pos == P_FC)) begin
                kind_q <= beat.data[3:2];
            end
        end
    end

    rxh_verdict i_verdict (
        .clk      (clk),
        .rst      (rst),
        .vd       (vd),
        .status_rd(status_rd),
        .status   (status_e),
        .irq      (host_irq),
        .accept   (frame_accept),
        .abort    (frame_abort)
    );

    assign rx_status  = status_e;
    assign hdr_ok     = hdr_ok_q;
    assign frame_kind = kind_q;

    AST_HDR_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
        hdr_ok |-> (!frame_abort && !frame_accept)); // R4
    AST_KIND_STABLE: assert property (@(posedge clk) disable iff (rst)
        hdr_ok |-> $stable(frame_kind)); // R4
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && !(rx_valid && rx_sof)) |=>
            (!frame_accept && !frame_abort && !hdr_ok)); // R7
    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && !rx_eof) |=> (state_q == SEQ_RUN)); // R9

endmodule

// File: tb/test_rxh_checker.sv
module test_rxh_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid;
    logic        rx_sof;
    logic        rx_eof;
    logic [7:0]  rx_data;
    logic [47:0] station_addr;
    logic        status_rd;
    logic        hdr_ok;
    logic [1:0]  frame_kind;
    logic        frame_accept;
    logic        frame_abort;
    logic [2:0]  rx_status;
    logic        host_irq;

    always #2 clk = ~clk;

    rxh_checker i_rxh_checker (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_data     (rx_data),
        .station_addr(station_addr),
        .status_rd   (status_rd),
        .hdr_ok      (hdr_ok),
        .frame_kind  (frame_kind),
        .frame_accept(frame_accept),
        .frame_abort (frame_abort),
        .rx_status   (rx_status),
        .host_irq    (host_irq)
    );

    localparam logic [47:0] SELF = 48'h5A_34_12_CD_AB_02;

    // fc[21:14] amode[13:12] corrupt[11:10] blen[9:6] status[5:3] hdr[2] kind[1:0]
    // amode: 0 own address, 1 group address, 2 foreign; corrupt: 1 header CRC, 2 FCS
    localparam int NVEC = 8;
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h08, 2'd0, 2'd0, 4'd5,  3'd0, 1'b1, 2'd2},
        {8'hD4, 2'd0, 2'd0, 4'd0,  3'd0, 1'b1, 2'd1},
        {8'h80, 2'd1, 2'd0, 4'd9,  3'd0, 1'b1, 2'd0},
        {8'h08, 2'd0, 2'd1, 4'd4,  3'd1, 1'b0, 2'd2},
        {8'h09, 2'd0, 2'd0, 4'd4,  3'd2, 1'b0, 2'd2},
        {8'h88, 2'd2, 2'd0, 4'd3,  3'd3, 1'b0, 2'd2},
        {8'h08, 2'd0, 2'd2, 4'd7,  3'd4, 1'b1, 2'd2},
        {8'h48, 2'd0, 2'd0, 4'd15, 3'd0, 1'b1, 2'd2}
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cyc      = 0;

    int acc_n = 0, ab_n = 0, hdr_n = 0;
    int acc_cyc = 0, ab_cyc = 0, hdr_cyc = 0;
    logic [1:0] kind_seen = 2'd0;

    logic [7:0] fb [64];
    int         flen;
    int         drv_cyc [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (frame_accept) begin acc_n <= acc_n + 1; acc_cyc <= cyc; end
        if (frame_abort)  begin ab_n  <= ab_n + 1;  ab_cyc  <= cyc; end
        if (hdr_ok) begin hdr_n <= hdr_n + 1; hdr_cyc <= cyc; kind_seen <= frame_kind; end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] hcrc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic build(input logic [7:0] fc, input int amode, input int corrupt, input int blen);
        logic [15:0] c16;
        logic [31:0] c32;
        logic [7:0]  a;
        int n;
        fb[0] = 8'h0A; fb[1] = 8'h00; fb[2] = 8'h40 + 8'(blen); fb[3] = 8'h00;
        c16 = 16'hFFFF;
        for (int i = 0; i < 4; i++) c16 = hcrc_byte(c16, fb[i]);
        fb[4] = c16[15:8];
        fb[5] = c16[7:0];
        if (corrupt == 1) fb[5] = fb[5] ^ 8'h10;
        fb[6] = fc; fb[7] = 8'h00; fb[8] = 8'h2C; fb[9] = 8'h00;
        for (int k = 0; k < 6; k++) begin
            a = SELF[k*8 +: 8];
            if (amode == 2 && k == 5) a = a ^ 8'h80;
            if (amode == 1) a = (k == 0) ? 8'h51 : 8'h77;
            fb[10+k] = a;
        end
        for (int k = 0; k < blen; k++) fb[16+k] = 8'(k * 37 + 5);
        n = 16 + blen;
        c32 = 32'hFFFFFFFF;
        for (int i = 6; i < n; i++) begin
            c32 = c32 ^ {24'h0, fb[i]};
            for (int j = 0; j < 8; j++)
                c32 = c32[0] ? ((c32 >> 1) ^ 32'hEDB88320) : (c32 >> 1);
        end
        c32 = ~c32;
        for (int k = 0; k < 4; k++) fb[n+k] = c32[k*8 +: 8];
        if (corrupt == 2) fb[n+1] = fb[n+1] ^ 8'h01;
        flen = n + 4;
    endtask

    task automatic drive(input int cut, input bit give_eof, input bit rd_last);
        int last = (cut >= 0) ? cut : flen - 1;
        for (int p = 0; p <= last; p++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (p == 0);
            rx_eof    = give_eof && (p == last);
            rx_data   = fb[p];
            status_rd = rd_last && (p == last);
            drv_cyc[p] = cyc;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; status_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic read_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        #1;
    endtask

    function automatic string req_of(input int st);
        case (st)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R5";
            default: return "R5";
        endcase
    endfunction

    initial begin
        int a0, b0, h0, dpos, st, ehdr, ek;
        string rq;
        rst = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_data = 8'h00; status_rd = 1'b0; station_addr = SELF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10", "status after reset", int'(rx_status), 0);
        chk("R10", "irq after reset", int'(host_irq), 0);
        chk("R10", "pulses after reset", int'({hdr_ok, frame_accept, frame_abort}), 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            st   = int'(VEC[v][5:3]);
            ehdr = int'(VEC[v][2]);
            ek   = int'(VEC[v][1:0]);
            rq   = req_of(st);
            a0 = acc_n; b0 = ab_n; h0 = hdr_n;
            build(VEC[v][21:14], int'(VEC[v][13:12]), int'(VEC[v][11:10]), int'(VEC[v][9:6]));
            drive(-1, 1'b1, 1'b0);
            settle();
            chk(rq, $sformatf("vec%0d status", v), int'(rx_status), st);
            chk(rq, $sformatf("vec%0d verdict count", v), (acc_n - a0) + (ab_n - b0), 1);
            chk(rq, $sformatf("vec%0d accept count", v), acc_n - a0, (st == 0) ? 1 : 0);
            case (st)
                1: dpos = 5;
                2: dpos = 6;
                3: dpos = 15;
                default: dpos = flen - 1;
            endcase
            chk("R11", $sformatf("vec%0d verdict cycle", v),
                (st == 0) ? acc_cyc : ab_cyc, drv_cyc[dpos] + 1);
            chk("R4", $sformatf("vec%0d hdr_ok count", v), hdr_n - h0, ehdr);
            if (ehdr == 1) begin
                chk("R4", $sformatf("vec%0d kind", v), int'(kind_seen), ek);
                chk("R11", $sformatf("vec%0d hdr_ok cycle", v), hdr_cyc, drv_cyc[15] + 1);
            end
            if (st == 1 || st == 2 || st == 3)
                chk("R7", $sformatf("vec%0d no pulse after abort", v), (acc_n - a0) + (hdr_n - h0), 0);
            chk("R8", $sformatf("vec%0d irq set", v), int'(host_irq), 1);
            read_status();
            chk("R8", $sformatf("vec%0d irq cleared by read", v), int'(host_irq), 0);
            chk("R8", $sformatf("vec%0d status kept by read", v), int'(rx_status), st);
        end

        // R6 early end flags
        build(8'h08, 0, 0, 4);
        b0 = ab_n;
        drive(3, 1'b1, 1'b0); settle();
        chk("R6", "eof inside phy header", int'(rx_status), 4);
        chk("R6", "eof inside phy header abort", ab_n - b0, 1);
        b0 = ab_n;
        drive(6, 1'b1, 1'b0); settle();
        chk("R6", "eof on frame control", int'(rx_status), 4);
        chk("R6", "eof on frame control cycle", ab_cyc, drv_cyc[6] + 1);
        b0 = ab_n; h0 = hdr_n;
        drive(15, 1'b1, 1'b0); settle();
        chk("R6", "eof on last address byte", int'(rx_status), 4);
        chk("R6", "eof on last address no hdr_ok", hdr_n - h0, 0);
        chk("R6", "eof on last address abort", ab_n - b0, 1);
        build(8'h09, 0, 0, 4);
        drive(6, 1'b1, 1'b0); settle();
        chk("R6", "version failure beats eof", int'(rx_status), 2);
        read_status();

        // R9 restart in the middle of a frame
        build(8'h08, 0, 0, 6);
        a0 = acc_n; b0 = ab_n;
        drive(11, 1'b0, 1'b0);
        drive(-1, 1'b1, 1'b0);
        settle();
        chk("R9", "restart accept count", acc_n - a0, 1);
        chk("R9", "restart abort count", ab_n - b0, 0);
        chk("R9", "restart status", int'(rx_status), 0);
        read_status();

        // R8 pending interrupt and simultaneous read
        build(8'h08, 0, 0, 2);
        drive(-1, 1'b1, 1'b0); settle();
        repeat (5) @(negedge clk);
        #1;
        chk("R8", "irq held while unread", int'(host_irq), 1);
        build(8'h08, 0, 2, 2);
        drive(-1, 1'b1, 1'b0); settle();
        chk("R8", "second result overwrites status", int'(rx_status), 4);
        chk("R8", "irq still set", int'(host_irq), 1);
        build(8'h08, 0, 0, 3);
        drive(-1, 1'b1, 1'b1); settle();
        chk("R8", "verdict wins over same-cycle read", int'(host_irq), 1);
        chk("R8", "status after same-cycle read", int'(rx_status), 0);
        read_status();
        chk("R8", "irq cleared afterwards", int'(host_irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule